// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block keeps the two thresholds that a FIFO's almost-empty and almost-full flags compare against: an empty offset and a full offset, each `log2(DEPTH)` bits wide. Each offset is split into a low part and a high part. That gives four slots, and they are always visited in a fixed order: empty low, empty high, full low, full high. When the control lines select offset access instead of memory access, software-side logic can write the slots one per write-clock edge from a parallel bus. It can also shift both offsets in as one serial stream of `2*log2(DEPTH)` bits, one bit per write-clock edge. Either way, it can read the slots back one per read-clock edge on the read bus.

The load method is fixed while master reset is held and stays fixed until the next reset. Readback works under either method. Control lines that select ordinary memory traffic or a no-operation code leave the offsets untouched. In the memory-traffic case the block raises the memory write or read enable for the FIFO storage. Master reset loads both offsets with default values. It also returns both slot pointers to the first slot and throws away any partly shifted serial stream.

Top module: `offset_prog_unit`

## Requirements
- R1: While `rstN` is low, each rising `clkW` edge sets both offsets to their defaults (127 for the default parameters), clears the serial position and puts the write slot pointer on the first slot. Each rising `clkR` edge under reset clears `dOut` and puts the read slot pointer on the first slot.
- R2: With `serialSel` low at reset, each rising `clkW` edge with ld=0, wen=0, ren=1, sen=1 writes `dIn` into the next slot, in the order empty low, empty high, full low, full high. The low part is offset bits [LO_W-1:0] from `dIn[LO_W-1:0]`, where LO_W = ceil(OFS_W/2). The high part is the remaining bits from the bottom of `dIn`. After the fourth slot the pointer returns to the empty low slot.
- R3: Each rising `clkR` edge with ld=0, wen=1, ren=0, sen=1 puts the next slot, zero-extended, on `dOut`. The slot order and the wrap are the same as in R2. At all other times `dOut` holds its value.
- R4: With `serialSel` high at reset, each rising `clkW` edge with ld=0, wen=1, ren=1, sen=0 takes one bit from `sdi`. Bit k (counting from 0) becomes empty offset bit k for k < OFS_W and full offset bit k-OFS_W otherwise. Both offsets update together on the edge that takes bit 2*OFS_W-1.
- R5: A serial stream that is not yet complete leaves both offsets unchanged. A master reset discards it, so the next stream starts again at bit 0.
- R6: In serial mode the parallel write code has no effect. In parallel mode the serial shift code has no effect.
- R7: The readback of R3 works under both load methods.
- R8: With ld=1, `memWrEn` equals !wen and `memRdEn` equals !ren, and the offsets do not change. With ld=0 both enables are low.
- R9: The no-operation code ld=0, wen=1, ren=1, sen=1 leaves the offsets, the pointers and `dOut` unchanged.
- R10: Once reset is released, a change on `serialSel` does not change the load method.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkW | input | 1 | Write-side clock; parallel and serial loading |
| clkR | input | 1 | Read-side clock; offset readback |
| rstN | input | 1 | Master reset, active low, synchronous |
| serialSel | input | 1 | Load method sampled under reset: 1 serial, 0 parallel |
| ld | input | 1 | Low selects offset access, high selects memory access |
| wen | input | 1 | Write enable, active low |
| ren | input | 1 | Read enable, active low |
| sen | input | 1 | Serial shift enable, active low |
| sdi | input | 1 | Serial offset data |
| dIn | input | BUS_W | Parallel write bus |
| dOut | output | BUS_W | Read bus carrying the slot read back |
| emptyOfs | output | OFS_W | Current empty offset |
| fullOfs | output | OFS_W | Current full offset |
| memWrEn | output | 1 | FIFO storage write enable |
| memRdEn | output | 1 | FIFO storage read enable |

## Verification
The bench writes a fifth slot to check that the write pointer wraps to the empty low slot. A design that did not wrap would corrupt the full high part or drop the write. Four reads then check that the read pointer wraps and that readback still works in serial mode. A design with one pointer shared between writing and reading, or with readback gated by the method, returns the wrong slot. The bench also stops a serial stream partway and checks that the offsets do not move. It then resets mid-stream and loads a fresh stream. A design that committed bits early or kept its bit count across reset would end up with shifted or mixed offsets. Finally, the bench drives the load code of the method that was not selected, and changes `serialSel` after reset. A design that let either through would alter the offsets.

// File: rtl/ofsprog_pkg.sv
package ofsprog_pkg;

  // Slot order is behaviour: loading and readback both walk it in this order.
  typedef enum logic [1:0] {
    SLOT_EMPTY_LO = 2'd0,
    SLOT_EMPTY_HI = 2'd1,
    SLOT_FULL_LO  = 2'd2,
    SLOT_FULL_HI  = 2'd3
  } slot_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic  wrSlot;    // parallel slot write this clkW edge
    slot_e wrIdx;     // slot being written
    logic  shiftBit;  // serial bit accepted this clkW edge
    logic  lastBit;   // this bit completes the stream
    logic  rdSlot;    // slot readback this clkR edge
    slot_e rdIdx;     // slot being read
  } strobe_t;

endpackage

// File: rtl/ofsprog_ctrl.sv
module ofsprog_ctrl
  import ofsprog_pkg::*;
#(
  parameter int CHAIN_W = 20,
  parameter int CNT_W   = 5
) (
  input  logic             clkW,
  input  logic             clkR,
  input  logic             rstN,
  input  logic             serialSel,
  input  logic             ld,
  input  logic             wen,
  input  logic             ren,
  input  logic             sen,
  output strobe_t          strb,
  output logic [CNT_W-1:0] bitIdx,
  output logic             methodSerial,
  output logic             memWrEn,
  output logic             memRdEn
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CHAIN_W - 1);

  logic [1:0] wrPtr;
  logic [1:0] rdPtr;
  logic       opWrite;
  logic       opShift;
  logic       opRead;

  // Shared control space decode
  assign opWrite = !ld && !wen &&  ren &&  sen;
  assign opShift = !ld &&  wen &&  ren && !sen;
  assign opRead  = !ld &&  wen && !ren &&  sen;

  assign memWrEn = ld && !wen;
  assign memRdEn = ld && !ren;

  // Load method is captured only while reset is held
  always_ff @(posedge clkW) begin
    if (!rstN) methodSerial <= serialSel;
  end

  always_comb begin
    strb.wrSlot   = opWrite && !methodSerial;
    strb.wrIdx    = slot_e'(wrPtr);
    strb.shiftBit = opShift && methodSerial;
    strb.lastBit  = (bitIdx == LAST_BIT);
    strb.rdSlot   = opRead;
    strb.rdIdx    = slot_e'(rdPtr);
  end

  always_ff @(posedge clkW) begin
    if (!rstN) begin
      wrPtr  <= 2'd0;
      bitIdx <= '0;
    end else begin
      if (strb.wrSlot) wrPtr <= wrPtr + 2'd1;
      if (strb.shiftBit) begin
        if (strb.lastBit) bitIdx <= '0;
        else              bitIdx <= bitIdx + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clkR) begin
    if (!rstN)            rdPtr <= 2'd0;
    else if (strb.rdSlot) rdPtr <= rdPtr + 2'd1;
  end

  p_method_hold_r10: assert property (@(posedge clkW) disable iff (!rstN)
    $past(rstN) |-> $stable(methodSerial));

  p_bit_range_r4: assert property (@(posedge clkW) disable iff (!rstN)
    bitIdx <= LAST_BIT);

  p_wr_wrap_r2: assert property (@(posedge clkW) disable iff (!rstN)
    (strb.wrSlot && wrPtr == 2'd3) |=> wrPtr == 2'd0);

  p_rd_wrap_r3: assert property (@(posedge clkR) disable iff (!rstN)
    (strb.rdSlot && rdPtr == 2'd3) |=> rdPtr == 2'd0);

endmodule

// File: rtl/ofsprog_dpath.sv
module ofsprog_dpath
  import ofsprog_pkg::*;
#(
  parameter int OFS_W     = 10,
  parameter int LO_W      = 5,
  parameter int HI_W      = 5,
  parameter int BUS_W     = 18,
  parameter int CHAIN_W   = 20,
  parameter int CNT_W     = 5,
  parameter int DEF_EMPTY = 127,
  parameter int DEF_FULL  = 127
) (
  input  logic             clkW,
  input  logic             clkR,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [CNT_W-1:0] bitIdx,
  input  logic             sdi,
  input  logic [BUS_W-1:0] dIn,
  output logic [OFS_W-1:0] emptyOfs,
  output logic [OFS_W-1:0] fullOfs,
  output logic [BUS_W-1:0] dOut
);

  logic [CHAIN_W-1:0] stage;
  logic [CHAIN_W-1:0] nextStage;
  logic [BUS_W-1:0]   slotVal;

  always_comb begin
    nextStage = stage;
    nextStage[bitIdx] = sdi;
  end

  always_ff @(posedge clkW) begin
    if (!rstN) begin
      emptyOfs <= OFS_W'(DEF_EMPTY);
      fullOfs  <= OFS_W'(DEF_FULL);
      stage    <= '0;
    end else begin
      if (strb.wrSlot) begin
        case (strb.wrIdx)
          SLOT_EMPTY_LO: emptyOfs[LO_W-1:0]     <= dIn[LO_W-1:0];
          SLOT_EMPTY_HI: emptyOfs[OFS_W-1:LO_W] <= dIn[HI_W-1:0];
          SLOT_FULL_LO:  fullOfs[LO_W-1:0]      <= dIn[LO_W-1:0];
          default:       fullOfs[OFS_W-1:LO_W]  <= dIn[HI_W-1:0];
        endcase
      end
      if (strb.shiftBit) begin
        if (strb.lastBit) begin
          emptyOfs <= nextStage[OFS_W-1:0];
          fullOfs  <= nextStage[CHAIN_W-1:OFS_W];
          stage    <= '0;
        end else begin
          stage <= nextStage;
        end
      end
    end
  end

  always_comb begin
    slotVal = '0;
    case (strb.rdIdx)
      SLOT_EMPTY_LO: slotVal[LO_W-1:0] = emptyOfs[LO_W-1:0];
      SLOT_EMPTY_HI: slotVal[HI_W-1:0] = emptyOfs[OFS_W-1:LO_W];
      SLOT_FULL_LO:  slotVal[LO_W-1:0] = fullOfs[LO_W-1:0];
      default:       slotVal[HI_W-1:0] = fullOfs[OFS_W-1:LO_W];
    endcase
  end

  always_ff @(posedge clkR) begin
    if (!rstN)            dOut <= '0;
    else if (strb.rdSlot) dOut <= slotVal;
  end

  p_partial_hold_r5: assert property (@(posedge clkW) disable iff (!rstN)
    (strb.shiftBit && !strb.lastBit) |=> ($stable(emptyOfs) && $stable(fullOfs)));

  p_bus_hold_r3: assert property (@(posedge clkR) disable iff (!rstN)
    !strb.rdSlot |=> $stable(dOut));

endmodule

// File: rtl/offset_prog_unit.sv
module offset_prog_unit
  import ofsprog_pkg::*;
#(
  parameter int DEPTH     = 1024,
  parameter int BUS_W     = 18,
  parameter int DEF_EMPTY = 127,
  parameter int DEF_FULL  = 127,
  localparam int OFS_W    = $clog2(DEPTH)
) (
  input  logic             clkW,
  input  logic             clkR,
  input  logic             rstN,
  input  logic             serialSel,
  input  logic             ld,
  input  logic             wen,
  input  logic             ren,
  input  logic             sen,
  input  logic             sdi,
  input  logic [BUS_W-1:0] dIn,
  output logic [BUS_W-1:0] dOut,
  output logic [OFS_W-1:0] emptyOfs,
  output logic [OFS_W-1:0] fullOfs,
  output logic             memWrEn,
  output logic             memRdEn
);

  localparam int LO_W    = (OFS_W + 1) / 2;
  localparam int HI_W    = OFS_W - LO_W;
  localparam int CHAIN_W = 2 * OFS_W;
  localparam int CNT_W   = $clog2(CHAIN_W);

  strobe_t          strb;
  logic [CNT_W-1:0] bitIdx;
  logic             methodSerial;

  ofsprog_ctrl #(.CHAIN_W(CHAIN_W), .CNT_W(CNT_W)) u_ctrl (
    .clkW(clkW), .clkR(clkR), .rstN(rstN), .serialSel(serialSel),
    .ld(ld), .wen(wen), .ren(ren), .sen(sen),
    .strb(strb), .bitIdx(bitIdx), .methodSerial(methodSerial),
    .memWrEn(memWrEn), .memRdEn(memRdEn)
  );

  ofsprog_dpath #(
    .OFS_W(OFS_W), .LO_W(LO_W), .HI_W(HI_W), .BUS_W(BUS_W),
    .CHAIN_W(CHAIN_W), .CNT_W(CNT_W),
    .DEF_EMPTY(DEF_EMPTY), .DEF_FULL(DEF_FULL)
  ) u_dpath (
    .clkW(clkW), .clkR(clkR), .rstN(rstN), .strb(strb), .bitIdx(bitIdx),
    .sdi(sdi), .dIn(dIn), .emptyOfs(emptyOfs), .fullOfs(fullOfs), .dOut(dOut)
  );

  p_ld_blocks_r8: assert property (@(posedge clkW) disable iff (!rstN)
    ld |=> ($stable(emptyOfs) && $stable(fullOfs)));

  p_noop_r9: assert property (@(posedge clkW) disable iff (!rstN)
    (!ld && wen && ren && sen) |=> ($stable(emptyOfs) && $stable(fullOfs)));

  p_par_locked_r6: assert property (@(posedge clkW) disable iff (!rstN)
    (methodSerial && !ld && !wen && ren && sen) |=> ($stable(emptyOfs) && $stable(fullOfs)));

  p_ser_locked_r6: assert property (@(posedge clkW) disable iff (!rstN)
    (!methodSerial && !ld && wen && ren && !sen) |=> ($stable(emptyOfs) && $stable(fullOfs)));

endmodule

// File: tb/sim_offset_prog_unit.sv
module sim_offset_prog_unit;

  localparam int CLK_W_PERIOD = 10;
  localparam int CLK_R_PERIOD = 14;
  localparam int OW = 10;
  localparam int LW = 5;
  localparam int BW = 18;

  logic clkW = 0, clkR = 0, rstN = 0, serialSel = 0;
  logic ld = 1, wen = 1, ren = 1, sen = 1, sdi = 0;
  logic [BW-1:0] dIn = '0;
  logic [BW-1:0] dOut;
  logic [OW-1:0] emptyOfs, fullOfs;
  logic memWrEn, memRdEn;

  int checks = 0, errors = 0;
  bit finished = 0;

  // Reference model
  int mE, mF, mWr, mRd, mCnt;
  bit mSerial;
  logic [2*OW-1:0] mStage;
  int expQ[$];

  offset_prog_unit #(.DEPTH(1024), .BUS_W(BW)) u0 (
    .clkW(clkW), .clkR(clkR), .rstN(rstN), .serialSel(serialSel),
    .ld(ld), .wen(wen), .ren(ren), .sen(sen), .sdi(sdi), .dIn(dIn),
    .dOut(dOut), .emptyOfs(emptyOfs), .fullOfs(fullOfs),
    .memWrEn(memWrEn), .memRdEn(memRdEn)
  );

  always #(CLK_W_PERIOD/2) clkW = ~clkW;
  always #(CLK_R_PERIOD/2) clkR = ~clkR;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int slotOf(input int idx);
    case (idx)
      0: return mE & ((1 << LW) - 1);
      1: return mE >> LW;
      2: return mF & ((1 << LW) - 1);
      default: return mF >> LW;
    endcase
  endfunction

  task automatic setIdle();
    ld = 1; wen = 1; ren = 1; sen = 1;
  endtask

  task automatic doReset(input bit sel);
    @(negedge clkW);
    rstN = 0; serialSel = sel; setIdle();
    repeat (5) @(negedge clkW);
    rstN = 1;
    mE = 127; mF = 127; mWr = 0; mRd = 0; mCnt = 0; mStage = '0; mSerial = sel;
    expQ.delete();
  endtask

  task automatic writeSlot(input int v);
    @(negedge clkW);
    ld = 0; wen = 0; ren = 1; sen = 1; dIn = BW'(v);
    @(negedge clkW);
    setIdle();
    if (!mSerial) begin
      case (mWr)
        0: mE = (mE & ~((1 << LW) - 1)) | (v & ((1 << LW) - 1));
        1: mE = (mE & ((1 << LW) - 1)) | ((v & ((1 << (OW - LW)) - 1)) << LW);
        2: mF = (mF & ~((1 << LW) - 1)) | (v & ((1 << LW) - 1));
        default: mF = (mF & ((1 << LW) - 1)) | ((v & ((1 << (OW - LW)) - 1)) << LW);
      endcase
      mWr = (mWr + 1) % 4;
    end
  endtask

  task automatic shiftOne(input bit b);
    @(negedge clkW);
    ld = 0; wen = 1; ren = 1; sen = 0; sdi = b;
    @(negedge clkW);
    setIdle();
    if (mSerial) begin
      mStage[mCnt] = b;
      mCnt++;
      if (mCnt == 2 * OW) begin
        mE = int'(mStage[OW-1:0]); mF = int'(mStage[2*OW-1:OW]);
        mCnt = 0; mStage = '0;
      end
    end
  endtask

  task automatic shiftStream(input logic [2*OW-1:0] pat, input int nBits);
    for (int k = 0; k < nBits; k++) shiftOne(pat[k]);
  endtask

  // Driver: pushes the expected slot, monitor compares it
  task automatic readSlot();
    @(negedge clkR);
    expQ.push_back(slotOf(mRd));
    mRd = (mRd + 1) % 4;
    ld = 0; wen = 1; ren = 0; sen = 1;
    @(negedge clkR);
    setIdle();
  endtask

  task automatic readAll(input string req);
    for (int s = 0; s < 4; s++) readSlot();
    @(negedge clkR);
    check(expQ.size() == 0, req, expQ.size(), 0);
  endtask

  // Monitor
  always @(posedge clkR) begin
    if (rstN && !ld && wen && !ren && sen) begin
      #1;
      if (expQ.size() == 0) check(0, "R3 unexpected read", int'(dOut), -1);
      else begin
        int e;
        e = expQ.pop_front();
        check(int'(dOut) == e, "R3/R7 readback slot", int'(dOut), e);
      end
    end
  end

  task automatic checkOfs(input string req);
    check(int'(emptyOfs) == mE, req, int'(emptyOfs), mE);
    check(int'(fullOfs) == mF, req, int'(fullOfs), mF);
  endtask

  initial begin
    #(CLK_W_PERIOD * 150000);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, parallel method
    doReset(0);
    @(negedge clkR);
    checkOfs("R1 defaults");
    check(dOut == '0, "R1 dOut cleared", int'(dOut), 0);
    check(!memWrEn && !memRdEn, "R8 idle enables", int'({memWrEn, memRdEn}), 0);
    readAll("R1 read pointer at first slot");

    // R2: parallel write in order, then wrap to empty low
    writeSlot(677); writeSlot(677 >> LW); writeSlot(316); writeSlot(316 >> LW);
    checkOfs("R2 four slots");
    writeSlot(7);
    checkOfs("R2 wrap to empty low");
    readAll("R3 readback order");
    readAll("R3 read pointer wrap");

    // R6: serial code ignored in parallel mode
    shiftStream(20'hFFFFF, 2 * OW);
    checkOfs("R6 serial ignored in parallel mode");

    // R9: no-op code
    @(negedge clkW);
    ld = 0; wen = 1; ren = 1; sen = 1; dIn = '1;
    repeat (3) @(negedge clkW);
    checkOfs("R9 no-op");
    setIdle();

    // R8: memory access codes
    @(negedge clkW);
    ld = 1; wen = 0; ren = 0; dIn = '1;
    #1;
    check(memWrEn && memRdEn, "R8 memory enables", int'({memWrEn, memRdEn}), 3);
    repeat (2) @(negedge clkW);
    checkOfs("R8 memory access leaves offsets");
    ld = 0; wen = 1; ren = 1; sen = 1;
    #1;
    check(!memWrEn && !memRdEn, "R8 enables low when ld=0", int'({memWrEn, memRdEn}), 0);
    setIdle();

    // R10: late change of serialSel has no effect
    serialSel = 1;
    shiftStream(20'hFFFFF, 2 * OW);
    checkOfs("R10 method stays parallel");

    // Serial mode
    doReset(1);
    @(negedge clkW);
    checkOfs("R1 defaults after second reset");
    writeSlot(0); writeSlot(0);
    checkOfs("R6 parallel write ignored in serial mode");

    // R4/R5: serial load with mid-stream check
    shiftStream({10'd300, 10'd45}, OW);
    checkOfs("R5 partial stream holds offsets");
    for (int k = OW; k < 2 * OW; k++) shiftOne(((20'(10'd300) << OW) >> k) & 1);
    check(int'(emptyOfs) == 45, "R4 serial empty offset", int'(emptyOfs), 45);
    check(int'(fullOfs) == 300, "R4 serial full offset", int'(fullOfs), 300);
    readAll("R7 readback in serial mode");

    // R5: reset discards a partial stream
    shiftStream(20'hABCDE, 7);
    doReset(1);
    serialSel = 0; // R10
    shiftStream({10'd513, 10'd2}, 2 * OW);
    check(int'(emptyOfs) == 2, "R5 fresh stream empty", int'(emptyOfs), 2);
    check(int'(fullOfs) == 513, "R5 fresh stream full", int'(fullOfs), 513);
    writeSlot(9);
    checkOfs("R10 parallel still locked out");

    repeat (4) @(negedge clkR);
    check(expQ.size() == 0, "R3 scoreboard drained", expQ.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule